// File: doc/BRIEF.md
# Dual-Input Long-Press Reset Controller

This block watches two active-low push buttons and drives two drive-low enables. The first enable is a debounced conjunction indicator. It turns on once both buttons have been held for the debounce interval. It turns off once either button has been released for that same interval. Contacts that bounce for less than the interval leave it unchanged.

The second enable is a one-shot reset pulse. It fires when both buttons have been held together, without a break, for a long setup period, and it then lasts for a fixed width. While the pulse runs, button activity has no effect on it. After the pulse, the controller stays locked. It accepts a new press only after both buttons have been released together for a full debounce interval. This prevents an accidental double reset from one long press.

All timing is counted in ticks from a clock prescaler. A tick is one millisecond at the default divider. The setup period is chosen from 6, 8, 10 or 12 s and the pulse width from 0.5, 1 or 2 s. A test can override the tick counts directly. Each output is a drive-low enable: 1 means the external open-drain transistor pulls the line low. Several such lines can therefore be wire-ORed.

Top module: `long_press_reset_ctrl`

## Requirements
- R1: After synchronous reset, both `rst_pull` and `and_pull` are 0 (1 means pull low). The controller starts armed, and both buttons are taken as released.
- R2: With the prescaler at one clock per tick, `rst_pull` first reads 1 SETUP_TICKS+2 clocks after both buttons are driven low. The 2 clocks are the two synchronizer stages. This holds only if both buttons stay low throughout.
- R3: If either button goes high for even one clock before the setup period completes, the setup count is cleared. A full new setup period with both buttons low is then needed.
- R4: A reset pulse lasts exactly PULSE_TICKS ticks.
- R5: Holding both buttons after the pulse has fired produces no further pulse. There is one pulse per press.
- R6: Releasing either or both buttons while the pulse is active does not shorten the pulse.
- R7: After a pulse, a new press is accepted only once both buttons have been high together for DEB_TICKS consecutive ticks. Releasing one button only, or releasing both for fewer ticks, leaves the controller locked.
- R8: `and_pull` becomes 1 DEB_TICKS+2 clocks (at one clock per tick) after both buttons are low, provided they stay low for at least DEB_TICKS ticks. It stays 1 while both remain low.
- R9: `and_pull` returns to 0 only after one or both buttons have been high for DEB_TICKS ticks. A change lasting fewer than DEB_TICKS ticks, in either direction, leaves `and_pull` unchanged.
- R10: Neither output depends on which button goes low first. All timing counts from the moment the second button goes low.
- R11: Setup selector values 0..3 map to 6000, 8000, 10000 and 12000 ticks. Pulse selector values 0..2 map to 500, 1000 and 2000 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_a_n | input | 1 | First push button, low when pressed, asynchronous |
| btn_b_n | input | 1 | Second push button, low when pressed, asynchronous |
| rst_pull | output | 1 | Reset pulse drive-low enable |
| and_pull | output | 1 | Debounced both-pressed drive-low enable |

## Verification
The embedded assertions check several rules on every cycle:
- a break in the press clears the setup count;
- a running pulse cannot be cut short;
- the locked state never fires again, and it leaves only once the debounced release is seen;
- the debouncers never change state before their count completes, and never change state while their input agrees with them.

Only the bench scenarios can show the exact pulse start cycle and width, and that timing does not depend on which button went low first. They also cover the short-release and one-button-release lockout cases, and the glitch boundary exactly at the debounce length.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

    typedef enum logic [1:0] {
        SHOT_ARMED  = 2'd0,
        SHOT_FIRING = 2'd1,
        SHOT_LOCKED = 2'd2
    } shot_state_e;

    typedef struct packed {
        logic a_low;
        logic b_low;
    } btn_pair_t;

    function automatic int setup_ms(input int sel);
        return 6000 + 2000 * sel;
    endfunction

    function automatic int pulse_ms(input int sel);
        case (sel)
            0:       return 500;
            1:       return 1000;
            default: return 2000;
        endcase
    endfunction

    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din_n,
    output logic [N-1:0] dout_n
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], din_n[i]};
        end
        assign dout_n[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/lpr_tick.sv
module lpr_tick #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = lpr_pkg::cnt_bits(DIV);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == W'(DIV - 1)) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == W'(DIV - 1));
endmodule

// File: rtl/lpr_debounce.sv
module lpr_debounce #(
    parameter int TICKS = 2,
    parameter bit INIT  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic level,
    output logic stable_q
);
    localparam int W = lpr_pkg::cnt_bits(TICKS);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            stable_q <= INIT;
            cnt      <= '0;
        end else if (level == stable_q) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == W'(TICKS - 1)) begin
                stable_q <= level;
                cnt      <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8: agreement between input and state keeps the state
    p_db_steady_r8: assert property (@(posedge clk) disable iff (rst)
        (level == stable_q) |=> $stable(stable_q));

    // R9: no change before the count has run its full length
    p_db_no_early_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt != W'(TICKS - 1)) |=> $stable(stable_q));
endmodule

// File: rtl/lpr_oneshot.sv
module lpr_oneshot
    import lpr_pkg::*;
#(
    parameter int SETUP_TICKS = 10000,
    parameter int PULSE_TICKS = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic both_low,
    input  logic rel_ok,
    output logic firing
);
    localparam int SW = cnt_bits(SETUP_TICKS);
    localparam int PW = cnt_bits(PULSE_TICKS);

    shot_state_e   state;
    logic [SW-1:0] scnt;
    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SHOT_ARMED;
            scnt  <= '0;
            pcnt  <= '0;
        end else begin
            case (state)
                SHOT_ARMED: begin
                    pcnt <= '0;
                    if (!both_low) begin
                        scnt <= '0;
                    end else if (tick) begin
                        if (scnt == SW'(SETUP_TICKS - 1)) begin
                            state <= SHOT_FIRING;
                            scnt  <= '0;
                        end else begin
                            scnt <= scnt + 1'b1;
                        end
                    end
                end
                SHOT_FIRING: begin
                    if (tick) begin
                        if (pcnt == PW'(PULSE_TICKS - 1)) begin
                            state <= SHOT_LOCKED;
                            pcnt  <= '0;
                        end else begin
                            pcnt <= pcnt + 1'b1;
                        end
                    end
                end
                SHOT_LOCKED: begin
                    if (rel_ok) state <= SHOT_ARMED;
                end
                default: state <= SHOT_ARMED;
            endcase
        end
    end

    assign firing = (state == SHOT_FIRING);

    // R2: an armed controller without both buttons held cannot fire
    p_fire_needs_press_r2: assert property (@(posedge clk) disable iff (rst)
        (state == SHOT_ARMED && !both_low) |=> (state == SHOT_ARMED));

    // R3: a break in the press clears the setup count
    p_setup_break_r3: assert property (@(posedge clk) disable iff (rst)
        (state == SHOT_ARMED && !both_low) |=> (scnt == '0));

    // R6: a running pulse continues until its count ends, whatever the buttons do
    p_pulse_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state == SHOT_FIRING && pcnt != PW'(PULSE_TICKS - 1)) |=> (state == SHOT_FIRING));

    // R5: the locked state never goes straight back to firing
    p_single_shot_r5: assert property (@(posedge clk) disable iff (rst)
        (state == SHOT_LOCKED) |=> (state != SHOT_FIRING));

    // R7: the lock is left only after the debounced release
    p_rearm_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (state == SHOT_LOCKED && !rel_ok) |=> (state == SHOT_LOCKED));
endmodule

// File: rtl/long_press_reset_ctrl.sv
module long_press_reset_ctrl
    import lpr_pkg::*;
#(
    parameter int TICK_DIV    = 50000,
    parameter int DEB_TICKS   = 2,
    parameter int SETUP_SEL   = 2,
    parameter int PULSE_SEL   = 0,
    parameter int SETUP_TICKS = setup_ms(SETUP_SEL),
    parameter int PULSE_TICKS = pulse_ms(PULSE_SEL)
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_a_n,
    input  logic btn_b_n,
    output logic rst_pull,
    output logic and_pull
);
    logic [1:0] sync_n;
    logic       tick;
    btn_pair_t  press;
    logic       both_low;
    logic       both_high;
    logic       rel_ok;
    logic       conj_q;
    logic       fire;

    lpr_sync #(.N(2), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din_n  ({btn_b_n, btn_a_n}),
        .dout_n (sync_n)
    );

    lpr_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign press.a_low = ~sync_n[0];
    assign press.b_low = ~sync_n[1];
    assign both_low    = press.a_low & press.b_low;
    assign both_high   = ~press.a_low & ~press.b_low;

    lpr_debounce #(.TICKS(DEB_TICKS), .INIT(1'b0)) u_conj_db (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .level    (both_low),
        .stable_q (conj_q)
    );

    lpr_debounce #(.TICKS(DEB_TICKS), .INIT(1'b1)) u_rel_db (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .level    (both_high),
        .stable_q (rel_ok)
    );

    lpr_oneshot #(.SETUP_TICKS(SETUP_TICKS), .PULSE_TICKS(PULSE_TICKS)) u_shot (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .both_low (both_low),
        .rel_ok   (rel_ok),
        .firing   (fire)
    );

    assign rst_pull = fire;
    assign and_pull = conj_q;

    // R1: both enables are inactive in the cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!rst_pull && !and_pull));
endmodule

// File: tb/test_long_press_reset_ctrl.sv
`timescale 1ns/1ps
module test_long_press_reset_ctrl;
    localparam int DEB = 4;
    localparam int SET = 20;
    localparam int PUL = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_a_n = 1'b1;
    logic btn_b_n = 1'b1;
    logic rst_pull;
    logic and_pull;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit in_p = 1'b0;
    int p_start = 0;
    int p_width = 0;
    int e_start = 0;
    bit finished = 1'b0;
    int c = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    long_press_reset_ctrl #(
        .TICK_DIV(1), .DEB_TICKS(DEB), .SETUP_TICKS(SET), .PULSE_TICKS(PUL)
    ) i_long_press_reset_ctrl (
        .clk(clk), .rst(rst), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
        .rst_pull(rst_pull), .and_pull(and_pull)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic chk_and(input bit expv, input string req);
        chk(and_pull == expv, req, int'(and_pull), int'(expv));
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_btn(input bit a, input bit b);
        btn_a_n = a;
        btn_b_n = b;
    endtask

    // driver side: queue the pulse a press must produce
    task automatic press_expect();
        c = cyc;
        set_btn(1'b0, 1'b0);
        exp_q.push_back(c + SET + 2);
    endtask

    // monitor: measure every pulse and compare with the queue
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (rst_pull) begin
                if (!in_p) begin
                    in_p    = 1'b1;
                    p_start = cyc;
                    p_width = 0;
                end
                p_width++;
            end else if (in_p) begin
                in_p = 1'b0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected pulse at cycle", p_start, -1);
                end else begin
                    e_start = exp_q.pop_front();
                    chk(p_start == e_start, "R2 pulse start", p_start, e_start);
                    chk(p_width == PUL, "R4 pulse width", p_width, PUL);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(rst_pull == 1'b0, "R1 rst_pull after reset", int'(rst_pull), 0);
        chk_and(1'b0, "R1 and_pull after reset");

        for (int i = 0; i < 4; i++)
            chk(lpr_pkg::setup_ms(i) == 6000 + 2000 * i, "R11 setup choice",
                lpr_pkg::setup_ms(i), 6000 + 2000 * i);
        chk(lpr_pkg::pulse_ms(0) == 500,  "R11 pulse choice 0", lpr_pkg::pulse_ms(0), 500);
        chk(lpr_pkg::pulse_ms(1) == 1000, "R11 pulse choice 1", lpr_pkg::pulse_ms(1), 1000);
        chk(lpr_pkg::pulse_ms(2) == 2000, "R11 pulse choice 2", lpr_pkg::pulse_ms(2), 2000);
        wait_n(5);

        // basic long press, held well past firing (R2 R4 R5 R8 R9)
        press_expect();
        wait_n(DEB + 1);
        chk_and(1'b0, "R8 before debounce end");
        wait_n(1);
        chk_and(1'b1, "R8 at debounce end");
        wait_n(SET + PUL + 40);
        chk_and(1'b1, "R8 held while both low");
        c = cyc;
        set_btn(1'b1, 1'b1);
        wait_n(DEB + 1);
        chk_and(1'b1, "R9 before release debounce end");
        wait_n(1);
        chk_and(1'b0, "R9 at release debounce end");
        wait_n(10);

        // interrupted setup restarts (R3)
        set_btn(1'b0, 1'b0);
        wait_n(15);
        set_btn(1'b1, 1'b0);
        wait_n(1);
        press_expect();
        wait_n(DEB + 2);
        chk_and(1'b1, "R9 one-clock release ignored");
        wait_n(SET + PUL + 10);
        set_btn(1'b1, 1'b1);
        wait_n(20);

        // press order does not matter (R10)
        for (int k = 0; k < 2; k++) begin
            if (k == 0) set_btn(1'b1, 1'b0);
            else        set_btn(1'b0, 1'b1);
            wait_n(7);
            press_expect();
            wait_n(DEB + 1);
            chk_and(1'b0, "R10 and_pull from second press");
            wait_n(1);
            chk_and(1'b1, "R10 and_pull from second press");
            wait_n(SET + PUL + 10);
            set_btn(1'b1, 1'b1);
            wait_n(20);
        end

        // release during the pulse (R6), then re-arm (R7)
        press_expect();
        wait_n(SET + 4);
        chk(rst_pull == 1'b1, "R6 pulse active before release", int'(rst_pull), 1);
        set_btn(1'b1, 1'b1);
        wait_n(PUL + 20);
        press_expect();
        wait_n(SET + PUL + 10);
        set_btn(1'b1, 1'b1);
        wait_n(20);

        // lockout after firing (R7)
        press_expect();
        wait_n(SET + PUL + 10);
        set_btn(1'b1, 1'b1);
        wait_n(DEB - 1);
        set_btn(1'b0, 1'b0);
        for (int j = 0; j < DEB + 4; j++) begin
            chk_and(1'b1, "R9 short release keeps and_pull");
            wait_n(1);
        end
        wait_n(SET + 10);
        set_btn(1'b1, 1'b0);
        wait_n(30);
        chk_and(1'b0, "R9 one button released");
        set_btn(1'b0, 1'b0);
        wait_n(SET + 10);
        chk(rst_pull == 1'b0, "R7 still locked", int'(rst_pull), 0);
        set_btn(1'b1, 1'b1);
        wait_n(30);
        press_expect();
        wait_n(SET + PUL + 10);
        set_btn(1'b1, 1'b1);
        wait_n(20);

        // debounce boundaries from idle (R8 R9)
        set_btn(1'b0, 1'b0);
        wait_n(DEB - 1);
        set_btn(1'b1, 1'b1);
        for (int j = 0; j < 8; j++) begin
            chk_and(1'b0, "R9 short press ignored");
            wait_n(1);
        end
        set_btn(1'b0, 1'b0);
        wait_n(DEB);
        set_btn(1'b1, 1'b1);
        wait_n(2);
        chk_and(1'b1, "R8 press of exactly debounce length");
        wait_n(DEB - 1);
        chk_and(1'b1, "R9 release not yet debounced");
        wait_n(1);
        chk_and(1'b0, "R9 release debounced");
        wait_n(SET + 10);

        chk(exp_q.size() == 0, "R2 every expected pulse seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule